// File: doc/BRIEF.md
# Two-Section Line-Scan Readout Sequencer

This block holds the digital sequencing of a linear image sensor built from two sections of pixels. Each section runs on its own clock and carries a single token through its pixel positions. A start pulse captured on a rising clock edge places the token on pixel 0. Each later edge moves it on by one pixel. While the token is inside a section, that section's output-enable is high and its pixel index shows where the token is. This output-enable takes the place of an analog output that would otherwise float. When the token reaches the last pixel, the section raises a one-cycle serial-out pulse. On the next edge the token leaves and the output is disabled.

A hold input per section marks the start of the integrator reset. Its rising edge raises two flags. The integrator-reset flag stays high for a fixed number of cycles, counted from the start or hold event. The sample-disconnect flag stays high until that window has ended and no token is left in the section.

A mode pin selects serial or parallel operation. In serial mode, section 2 is started by section 1's serial-out, so a single scan walks through both sections in turn. In parallel mode, each section takes its own start pin and the two run independently.

Top module: `lscan_seq`

## Requirements
- R1: While `rst_n` is low, every output is forced to 0 at once, without waiting for a clock edge: serial-outs, output-enables, pixel indices, reset flags and disconnect flags.
- R2: After a rising clock edge on which a section's start is 1, that section has `oe`=1 and `pix`=0. Each following edge with no new start adds one to `pix`.
- R3: Count the capture edge as edge 1. A section's serial-out is high after edge PIXELS (640) only, and at that point `pix` is PIXELS-1. Edge PIXELS+1 clears both the serial-out and `oe`. Outside a scan, `oe` is 0.
- R4: With `serial_mode`=1, section 2 starts from `so1`. Counting the edge that captures `si1` as edge 1, `oe2` rises with `pix2`=0 after edge PIXELS+1, `so2` is high after edge 2*PIXELS only, and edge 2*PIXELS+1 clears `oe2`.
- R5: With `serial_mode`=0, section 2 starts only from `si2`. A pulse on `so1` does not disturb a scan in section 2 or start one there.
- R6: A start captured while a token is in flight moves the token back to pixel 0 and discards the old token. Only one serial-out pulse follows, timed from the newest start.
- R7: A rising edge on a section's hold input, captured on a clock edge, sets `int_rst` and `samp_off` after that edge. A hold pulse alone does not enable the output.
- R8: A start or a hold rising edge reloads a window of RST_CYCLES (18) cycles. `int_rst` stays high through that window, falls on the edge RST_CYCLES after the event, and is then never high unless `samp_off` is also high.
- R9: `samp_off` stays high until the window has ended and the section holds no token. After a full-length scan it falls on the same edge as `oe`.
- R10: A hold input held high does not retrigger the flags. Only a 0-to-1 change counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1 | input | 1 | Section 1 clock |
| clk2 | input | 1 | Section 2 clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | 1: section 2 starts from section 1's serial-out; 0: from `si2` |
| si1 | input | 1 | Section 1 start pulse |
| si2 | input | 1 | Section 2 start pulse (parallel mode) |
| hold1 | input | 1 | Section 1 hold; rising edge begins integrator reset |
| hold2 | input | 1 | Section 2 hold |
| so1 | output | 1 | Section 1 serial-out pulse |
| so2 | output | 1 | Section 2 serial-out pulse |
| oe1 | output | 1 | Section 1 output enable |
| oe2 | output | 1 | Section 2 output enable |
| pix1 | output | $clog2(PIXELS) | Section 1 token position, valid while `oe1` |
| pix2 | output | $clog2(PIXELS) | Section 2 token position, valid while `oe2` |
| int_rst1 | output | 1 | Section 1 integrator-reset flag |
| int_rst2 | output | 1 | Section 2 integrator-reset flag |
| samp_off1 | output | 1 | Section 1 sample-disconnect flag |
| samp_off2 | output | 1 | Section 2 sample-disconnect flag |

## Verification
Every result is a registered function of the capture edge e of a start or hold pulse. `oe`, `pix`, `int_rst` and `samp_off` change after edge e. The serial-out is due after edge e+PIXELS-1 and falls at e+PIXELS. In serial mode, section 2's serial-out is due after edge e+2*PIXELS-1. `int_rst` falls at e+RST_CYCLES. The bench records e at the negedge before the capture and pushes the expected serial-out edge into a per-section queue. A monitor compares each rising serial-out against that edge number. Direct checks wait at the negedge for the exact edge count, so no sample sits on a clock edge.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

   // Token storage variant for one section.
   typedef enum logic {
      TOK_SHIFT = 1'b0,   // one flop per pixel, token walks a chain
      TOK_COUNT = 1'b1    // run flag plus binary position counter
   } tok_style_e;

   localparam int unsigned DEF_PIXELS     = 640;
   localparam int unsigned DEF_RST_CYCLES = 18;

endpackage

// File: rtl/lscan_token.sv
module lscan_token
   import lscan_pkg::*;
#(
   parameter int unsigned PIXELS = DEF_PIXELS,
   parameter tok_style_e  STYLE  = TOK_SHIFT,
   parameter int unsigned PIX_W  = $clog2(PIXELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             act,
   output logic             last,
   output logic [PIX_W-1:0] pix
);

   localparam logic [PIX_W-1:0] LAST_POS = PIX_W'(PIXELS - 1);

   if (PIXELS < 2) begin : g_bad_pixels
      $error("lscan_token: PIXELS must be at least 2");
   end
   if (PIX_W != $clog2(PIXELS)) begin : g_bad_width
      $error("lscan_token: PIX_W must equal clog2(PIXELS)");
   end

   if (STYLE == TOK_SHIFT) begin : g_shift
      logic [PIXELS-1:0] chain_q;
      logic [PIX_W-1:0]  where;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else if (start) begin
            chain_q <= {{(PIXELS-1){1'b0}}, 1'b1};
         end else begin
            chain_q <= chain_q << 1;
         end
      end

      // Position encoder: only one bit of the chain can be set.
      always_comb begin
         where = '0;
         for (int i = 0; i < PIXELS; i++) begin
            if (chain_q[i]) begin
               where = where | PIX_W'(i);
            end
         end
      end

      assign act  = |chain_q;
      assign last = chain_q[PIXELS-1];
      assign pix  = where;
   end else begin : g_count
      logic             run_q;
      logic [PIX_W-1:0] pos_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= 1'b0;
            pos_q <= '0;
         end else if (start) begin
            run_q <= 1'b1;
            pos_q <= '0;
         end else if (run_q) begin
            if (pos_q == LAST_POS) begin
               run_q <= 1'b0;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end

      assign act  = run_q;
      assign last = run_q && (pos_q == LAST_POS);
      assign pix  = pos_q;
   end

endmodule

// File: rtl/lscan_window.sv
module lscan_window
   import lscan_pkg::*;
#(
   parameter int unsigned RST_CYCLES = DEF_RST_CYCLES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hold,
   input  logic tok_act,
   input  logic tok_last,
   output logic int_rst,
   output logic samp_off
);

   localparam int unsigned      CNT_W  = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RST_CYCLES);

   if (RST_CYCLES < 1) begin : g_bad_window
      $error("lscan_window: RST_CYCLES must be at least 1");
   end

   logic             hold_q;
   logic             hold_rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             win_busy_nxt;
   logic             tok_nxt;
   logic             int_rst_q;
   logic             samp_q;

   assign hold_rise = hold & ~hold_q;

   always_comb begin
      if (start || hold_rise) begin
         cnt_d = RELOAD;
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - 1'b1;
      end else begin
         cnt_d = '0;
      end
   end

   assign win_busy_nxt = (cnt_d != '0);
   // Token presence after this edge.
   assign tok_nxt      = start | (tok_act & ~tok_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= 1'b0;
         cnt_q     <= '0;
         int_rst_q <= 1'b0;
         samp_q    <= 1'b0;
      end else begin
         hold_q    <= hold;
         cnt_q     <= cnt_d;
         int_rst_q <= hold_rise | (int_rst_q & win_busy_nxt);
         samp_q    <= hold_rise | (samp_q & (win_busy_nxt | tok_nxt));
      end
   end

   assign int_rst  = int_rst_q;
   assign samp_off = samp_q;

endmodule

// File: rtl/lscan_section.sv
module lscan_section
   import lscan_pkg::*;
#(
   parameter int unsigned PIXELS     = DEF_PIXELS,
   parameter int unsigned RST_CYCLES = DEF_RST_CYCLES,
   parameter tok_style_e  STYLE      = TOK_SHIFT,
   parameter int unsigned PIX_W      = $clog2(PIXELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             hold,
   output logic             so,
   output logic             oe,
   output logic [PIX_W-1:0] pix,
   output logic             int_rst,
   output logic             samp_off
);

   logic tok_act;
   logic tok_last;

   lscan_token #(
      .PIXELS (PIXELS),
      .STYLE  (STYLE),
      .PIX_W  (PIX_W)
   ) u_token (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .act   (tok_act),
      .last  (tok_last),
      .pix   (pix)
   );

   lscan_window #(
      .RST_CYCLES (RST_CYCLES)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .hold     (hold),
      .tok_act  (tok_act),
      .tok_last (tok_last),
      .int_rst  (int_rst),
      .samp_off (samp_off)
   );

   assign so = tok_last;
   assign oe = tok_act;

endmodule

// File: rtl/lscan_seq.sv
module lscan_seq
   import lscan_pkg::*;
#(
   parameter int unsigned PIXELS     = DEF_PIXELS,
   parameter int unsigned RST_CYCLES = DEF_RST_CYCLES,
   parameter tok_style_e  STYLE      = TOK_SHIFT,
   parameter int unsigned PIX_W      = $clog2(PIXELS)
) (
   input  logic             clk1,
   input  logic             clk2,
   input  logic             rst_n,
   input  logic             serial_mode,
   input  logic             si1,
   input  logic             si2,
   input  logic             hold1,
   input  logic             hold2,
   output logic             so1,
   output logic             so2,
   output logic             oe1,
   output logic             oe2,
   output logic [PIX_W-1:0] pix1,
   output logic [PIX_W-1:0] pix2,
   output logic             int_rst1,
   output logic             int_rst2,
   output logic             samp_off1,
   output logic             samp_off2
);

   if (PIXELS < 2) begin : g_bad_pixels
      $error("lscan_seq: PIXELS must be at least 2");
   end
   if (PIX_W != $clog2(PIXELS)) begin : g_bad_width
      $error("lscan_seq: PIX_W must equal clog2(PIXELS)");
   end

   logic sec1_so;
   logic sec2_start;

   // Chain selection: section 2 follows section 1 in serial mode.
   assign sec2_start = serial_mode ? sec1_so : si2;

   lscan_section #(
      .PIXELS     (PIXELS),
      .RST_CYCLES (RST_CYCLES),
      .STYLE      (STYLE),
      .PIX_W      (PIX_W)
   ) u_sec1 (
      .clk      (clk1),
      .rst_n    (rst_n),
      .start    (si1),
      .hold     (hold1),
      .so       (sec1_so),
      .oe       (oe1),
      .pix      (pix1),
      .int_rst  (int_rst1),
      .samp_off (samp_off1)
   );

   lscan_section #(
      .PIXELS     (PIXELS),
      .RST_CYCLES (RST_CYCLES),
      .STYLE      (STYLE),
      .PIX_W      (PIX_W)
   ) u_sec2 (
      .clk      (clk2),
      .rst_n    (rst_n),
      .start    (sec2_start),
      .hold     (hold2),
      .so       (so2),
      .oe       (oe2),
      .pix      (pix2),
      .int_rst  (int_rst2),
      .samp_off (samp_off2)
   );

   assign so1 = sec1_so;

endmodule

// File: rtl/lscan_seq_chk.sv
module lscan_seq_chk #(
   parameter int unsigned PIXELS = 640,
   parameter int unsigned PIX_W  = $clog2(PIXELS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             si,
   input logic             hold,
   input logic             so,
   input logic             oe,
   input logic [PIX_W-1:0] pix,
   input logic             int_rst,
   input logic             samp_off
);

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      si |=> oe && (pix == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !so && !si) |=> oe && (pix == PIX_W'($past(pix) + 1'b1)));

   assert_so_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      so |-> oe && (pix == PIX_W'(PIXELS - 1)));

   assert_so_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (so && !si) |=> !so && !oe);

   assert_oe_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) |-> $past(so));

   assert_flags_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold) |=> int_rst && samp_off);

   assert_window_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int_rst |-> samp_off);

endmodule

bind lscan_seq lscan_seq_chk #(.PIXELS(PIXELS), .PIX_W(PIX_W)) u_chk_sec1 (
   .clk      (clk1),
   .rst_n    (rst_n),
   .si       (si1),
   .hold     (hold1),
   .so       (so1),
   .oe       (oe1),
   .pix      (pix1),
   .int_rst  (int_rst1),
   .samp_off (samp_off1)
);

bind lscan_seq lscan_seq_chk #(.PIXELS(PIXELS), .PIX_W(PIX_W)) u_chk_sec2 (
   .clk      (clk2),
   .rst_n    (rst_n),
   .si       (serial_mode ? so1 : si2),
   .hold     (hold2),
   .so       (so2),
   .oe       (oe2),
   .pix      (pix2),
   .int_rst  (int_rst2),
   .samp_off (samp_off2)
);

// File: tb/lscan_seq_tb.sv
module lscan_seq_tb;
   import lscan_pkg::*;

   localparam int N  = 640;
   localparam int RW = 18;
   localparam int PW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic serial_mode = 1'b1;
   logic si1 = 1'b0, si2 = 1'b0, hold1 = 1'b0, hold2 = 1'b0;
   logic so1, so2, oe1, oe2, int_rst1, int_rst2, samp_off1, samp_off2;
   logic [PW-1:0] pix1, pix2;

   int edge_n = 0;
   int checks = 0;
   int errors = 0;
   int q1[$];
   int q2[$];
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   always @(posedge clk) edge_n <= edge_n + 1;

   lscan_seq #(
      .PIXELS     (N),
      .RST_CYCLES (RW),
      .STYLE      (TOK_SHIFT),
      .PIX_W      (PW)
   ) u_dut (
      .clk1 (clk), .clk2 (clk), .rst_n (rst_n), .serial_mode (serial_mode),
      .si1 (si1), .si2 (si2), .hold1 (hold1), .hold2 (hold2),
      .so1 (so1), .so2 (so2), .oe1 (oe1), .oe2 (oe2),
      .pix1 (pix1), .pix2 (pix2),
      .int_rst1 (int_rst1), .int_rst2 (int_rst2),
      .samp_off1 (samp_off1), .samp_off2 (samp_off2)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edge_n);
      end
   endtask

   task automatic wait_to(input int k);
      while (edge_n < k) @(negedge clk);
   endtask

   // Drives one-cycle pulses at a negedge; returns the capture edge number.
   task automatic pulse(input bit s1, input bit s2, input bit h1, input bit h2, output int e);
      e = edge_n + 1;
      si1 = s1; si2 = s2; hold1 = h1; hold2 = h2;
      @(negedge clk);
      si1 = 1'b0; si2 = 1'b0; hold1 = 1'b0; hold2 = 1'b0;
   endtask

   // Scoreboard monitor: each serial-out rise must match the queued edge.
   bit p1 = 0, p2 = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         p1 = 0; p2 = 0;
      end else begin
         if (so1 && !p1) begin
            if (q1.size() == 0) chk("R3 so1 unexpected pulse", edge_n, -1);
            else chk("R3 so1 pulse edge", edge_n, q1.pop_front());
         end
         if (so2 && !p2) begin
            if (q2.size() == 0) chk("R4 so2 unexpected pulse", edge_n, -1);
            else chk("R4 so2 pulse edge", edge_n, q2.pop_front());
         end
         p1 = so1; p2 = so2;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int e, e2, h;
      // ---------------- R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 so1", so1, 0); chk("R1 so2", so2, 0);
      chk("R1 oe1", oe1, 0); chk("R1 oe2", oe2, 0);
      chk("R1 int_rst1", int_rst1, 0); chk("R1 samp_off2", samp_off2, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // ---------------- Serial scan through both sections (R2 R3 R4 R7 R8 R9)
      serial_mode = 1'b1;
      pulse(1, 0, 1, 1, e);
      q1.push_back(e + N - 1);
      q2.push_back(e + 2*N - 1);
      chk("R2 oe1 after start", oe1, 1);
      chk("R2 pix1 after start", pix1, 0);
      chk("R7 int_rst1 set", int_rst1, 1);
      chk("R7 samp_off1 set", samp_off1, 1);
      chk("R7 int_rst2 set", int_rst2, 1);
      chk("R4 oe2 idle in first half", oe2, 0);
      wait_to(e + 5);
      chk("R2 pix1 step", pix1, 5);
      wait_to(e + RW - 1);
      chk("R8 int_rst1 still high", int_rst1, 1);
      wait_to(e + RW);
      chk("R8 int_rst1 window end", int_rst1, 0);
      chk("R8 int_rst2 window end", int_rst2, 0);
      chk("R9 samp_off1 held during scan", samp_off1, 1);
      wait_to(e + N - 1);
      chk("R3 so1 high", so1, 1);
      chk("R3 pix1 last", pix1, N - 1);
      wait_to(e + N);
      chk("R3 so1 cleared", so1, 0);
      chk("R3 oe1 cleared", oe1, 0);
      chk("R9 samp_off1 cleared with oe1", samp_off1, 0);
      chk("R4 oe2 start", oe2, 1);
      chk("R4 pix2 start", pix2, 0);
      wait_to(e + 2*N - 1);
      chk("R4 so2 high", so2, 1);
      chk("R4 pix2 last", pix2, N - 1);
      wait_to(e + 2*N);
      chk("R4 so2 cleared", so2, 0);
      chk("R4 oe2 cleared", oe2, 0);
      repeat (4) @(negedge clk);

      // ---------------- Parallel, staggered starts (R5)
      serial_mode = 1'b0;
      pulse(1, 0, 1, 0, e);
      q1.push_back(e + N - 1);
      repeat (6) @(negedge clk);
      pulse(0, 1, 0, 1, e2);
      q2.push_back(e2 + N - 1);
      chk("R5 gap", e2 - e, 7);
      wait_to(e + N);
      chk("R5 oe1 done", oe1, 0);
      chk("R5 oe2 continues", oe2, 1);
      chk("R5 pix2 undisturbed by so1", pix2, N - 7);
      wait_to(e2 + N);
      chk("R5 oe2 done", oe2, 0);
      repeat (4) @(negedge clk);

      // ---------------- Parallel, section 1 alone leaves section 2 idle (R5)
      pulse(1, 0, 0, 0, e);
      q1.push_back(e + N - 1);
      wait_to(e + N + 1);
      chk("R5 oe2 not started by so1", oe2, 0);
      repeat (4) @(negedge clk);

      // ---------------- Restart in flight (R6)
      pulse(1, 0, 1, 0, e);
      q1.push_back(e + N - 1);
      wait_to(e + 100);
      q1.delete();
      pulse(1, 0, 1, 0, e2);
      q1.push_back(e2 + N - 1);
      chk("R6 pix1 back to 0", pix1, 0);
      chk("R6 int_rst1 retriggered", int_rst1, 1);
      wait_to(e + N);
      chk("R6 old token gone, oe1 on", oe1, 1);
      chk("R6 pix1 from new start", pix1, e + N - e2);
      wait_to(e2 + N);
      chk("R6 oe1 done", oe1, 0);
      repeat (4) @(negedge clk);

      // ---------------- Hold alone, held high (R7 R8 R10)
      h = edge_n + 1;
      hold1 = 1'b1;
      @(negedge clk);
      chk("R7 hold alone int_rst1", int_rst1, 1);
      chk("R7 hold alone samp_off1", samp_off1, 1);
      chk("R7 hold alone oe1", oe1, 0);
      wait_to(h + RW - 1);
      chk("R8 hold window high", int_rst1, 1);
      wait_to(h + RW);
      chk("R8 hold window end", int_rst1, 0);
      chk("R9 samp_off1 idle clear", samp_off1, 0);
      wait_to(h + 30);
      chk("R10 level hold no retrigger", int_rst1, 0);
      hold1 = 1'b0;
      repeat (4) @(negedge clk);

      // ---------------- Asynchronous reset mid-scan (R1)
      pulse(1, 0, 1, 0, e);
      wait_to(e + 10);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R1 async oe1", oe1, 0);
      chk("R1 async int_rst1", int_rst1, 0);
      chk("R1 async samp_off1", samp_off1, 0);
      q1.delete();
      @(negedge clk);
      rst_n = 1'b1;
      repeat (N + 4) @(negedge clk);

      chk("R3 no missing so pulses", q1.size() + q2.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule